// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Core

This block is a synchronous single-port memory whose control behaves like a pipelined burst cache SRAM. Each word is 32 bits wide and split into four byte lanes. The depth is a small parameter. An access begins on a clock edge where one of two address strobes is low. The processor strobe is honoured only while chip enable is low, and it always begins a read. The controller strobe is taken whatever chip enable says, and it may begin a write. A cycle that begins while the three select terms do not all agree is a deselect.

On edges where both strobes are high, an engaged access continues. A low advance input steps a two-bit beat counter. The counter produces the low address bits, in linear or interleaved order, and wraps after four beats. A high advance input holds the current address. Read data is registered twice: once with the access address and once out of the array. A word therefore appears after the edge that follows the edge on which its address was taken. A registered valid flag marks each such word.

The data output is qualified by an asynchronous output enable and by a sleep input. Sleep freezes all internal state. The first edge after sleep ends is always treated as a deselect.

Top module: `psram_burst_core`

## Requirements
- R1: The chip counts as selected only when ce_n_i is 0, sel_hi_i is 1 and sel_lo_n_i is 0. A strobe edge that is not selected is a deselect: it writes nothing, rvalid_o is 0 after the following edge, and later both-strobes-high edges neither read nor write until a new selected start.
- R2: cpu_strobe_n_i low is ignored while ce_n_i is 1. Such an edge behaves as a both-strobes-high edge, so an engaged burst keeps going.
- R3: For a read access taken on edge N, rvalid_o is 1 and rdata_o holds the word after edge N+1.
- R4: On a start edge the beat counter is cleared and addr_i is used as given. Each later edge with adv_n_i = 0 advances the counter by one, modulo 4. The low two address bits are then base+beat modulo 4 when linear_i = 1, and base XOR beat when linear_i = 0. The upper bits stay at the started address.
- R5: A both-strobes-high edge with adv_n_i = 1 accesses the same address as the previous access edge.
- R6: all_wr_n_i = 0 on a write-capable edge writes all four lanes, whatever lane_wr_en_n_i and lane_sel_n_i say.
- R7: With all_wr_n_i = 1 and lane_wr_en_n_i = 0, lane k (bits 8k+7:8k, k = 0..3) is written exactly when lane_sel_n_i[k] = 0. With all_wr_n_i = 1 and lane_wr_en_n_i = 1, nothing is written and the edge is a read.
- R8: An edge with cpu_strobe_n_i = 0 and ce_n_i = 0 ignores all write controls and starts a read. This also holds when ctl_strobe_n_i is low on the same edge.
- R9: A selected edge with only ctl_strobe_n_i low and an active write control writes wdata_i at addr_i on that same edge.
- R10: After any write edge N, rvalid_o is 0 after edge N+1.
- R11: oe_n_i = 1 forces rvalid_o to 0 and rdata_o to 0 at once, without waiting for a clock edge.
- R12: While sleep_i = 1, rvalid_o and rdata_o are 0, and no write, burst step or pipeline change takes place. The first edge with sleep_i = 0 after a sleeping edge is a deselect whatever the other inputs are.
- R13: After reset, rvalid_o and rdata_o are 0 and no access is engaged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_i | input | 1 | Freeze internal state and silence the output while high |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved (hold static) |
| ce_n_i | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel_hi_i | input | 1 | Chip select term, active high |
| sel_lo_n_i | input | 1 | Chip select term, active low |
| cpu_strobe_n_i | input | 1 | Processor address strobe, active low, read-only start |
| ctl_strobe_n_i | input | 1 | Controller address strobe, active low, ungated |
| adv_n_i | input | 1 | Burst advance, active low |
| all_wr_n_i | input | 1 | Write all lanes, active low, overrides lane controls |
| lane_wr_en_n_i | input | 1 | Lane write enable, active low |
| lane_sel_n_i | input | 4 | Per-lane write selects, active low, bit k for bits 8k+7:8k |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| addr_i | input | ADDR_W | Word address taken on start edges |
| wdata_i | input | 32 | Write data, used on the write edge |
| rdata_o | output | 32 | Read word, 0 when not driven |
| rvalid_o | output | 1 | Read word is being driven |

## Verification
On every cycle, the assertions check the following. A deselect or a write always empties the read pipeline stage behind it. A processor-strobe start never raises a lane write. A global write always covers every lane. The beat counter clears on a start and holds on a non-advancing edge. Sleep holds the pipeline still, and the edge after waking always decodes as a deselect. The bench scenarios alone show that the data is right: the burst order for every start address in both orders with wrap, the byte-lane merges across all sixteen select patterns, that a deselected or sleeping write leaves the array untouched, and the exact cycle on which a word emerges or vanishes.

// File: rtl/psram_pkg.sv
// Shared constants, cycle classification and burst address arithmetic
// for the pipelined burst SRAM control core.
package psram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_DESEL,
        CYC_START_RD,
        CYC_START_WR,
        CYC_CONT_RD,
        CYC_CONT_WR
    } cyc_kind_t;

    // Low address bits for a beat: linear adds, interleaved XORs.
    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] beat,
        input logic               linear
    );
        return linear ? (base + beat) : (base ^ beat);
    endfunction

endpackage

// File: rtl/psram_cycle_decode.sv
// Classifies each clock edge from the strobes, selects and write controls.
// Produces the cycle kind and the per-lane write enables.
// Assumes: wake_i is high on the first awake edge after sleep; engaged_i
// says a selected start has happened since the last deselect.
module psram_cycle_decode
    import psram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             wake_i,
    input  logic             engaged_i,
    input  logic             ce_n_i,
    input  logic             sel_hi_i,
    input  logic             sel_lo_n_i,
    input  logic             cpu_strobe_n_i,
    input  logic             ctl_strobe_n_i,
    input  logic             all_wr_n_i,
    input  logic             lane_wr_en_n_i,
    input  logic [LANES-1:0] lane_sel_n_i,
    output cyc_kind_t        kind_o,
    output logic [LANES-1:0] lane_we_o
);

    logic             cpu_go;
    logic             ctl_go;
    logic             selected;
    logic [LANES-1:0] lane_mask;
    logic             wr_req;

    // Strobe qualification, chip selection and requested lane mask.
    always_comb begin
        cpu_go    = ~cpu_strobe_n_i & ~ce_n_i;
        ctl_go    = ~ctl_strobe_n_i;
        selected  = ~ce_n_i & sel_hi_i & ~sel_lo_n_i;
        if (!all_wr_n_i)
            lane_mask = '1;
        else if (!lane_wr_en_n_i)
            lane_mask = ~lane_sel_n_i;
        else
            lane_mask = '0;
        wr_req = |lane_mask;
    end

    // Cycle kind: wake, then starts, then continuation of an engaged access.
    always_comb begin
        if (wake_i)
            kind_o = CYC_DESEL;
        else if (cpu_go || ctl_go) begin
            if (!selected)
                kind_o = CYC_DESEL;
            else if (cpu_go || !wr_req)
                kind_o = CYC_START_RD;
            else
                kind_o = CYC_START_WR;
        end else if (engaged_i)
            kind_o = wr_req ? CYC_CONT_WR : CYC_CONT_RD;
        else
            kind_o = CYC_IDLE;
    end

    // Lane enables only on write kinds.
    always_comb begin
        if (kind_o == CYC_START_WR || kind_o == CYC_CONT_WR)
            lane_we_o = lane_mask;
        else
            lane_we_o = '0;
    end

    // Guard the write gating rules.
    always_comb begin
        AST_CPU_NO_WRITE: assert (!(cpu_go && !wake_i && (lane_we_o != '0))) else $error("processor start wrote"); // R8
        AST_GLOBAL_FULL: assert (!((kind_o == CYC_START_WR || kind_o == CYC_CONT_WR) && !all_wr_n_i && (lane_we_o != '1))) else $error("global write partial"); // R6
    end

endmodule

// File: rtl/psram_burst_seq.sv
// Burst address sequencer. It holds the started address and a beat
// counter, and gives the address of the current edge's access.
// Assumes: linear_i is static while a burst is engaged; step_i is only
// raised on continuation edges.
module psram_burst_seq
    import psram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              linear_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] acc_addr_o
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    hi_q;
    logic [BURST_W-1:0] base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] beat_nxt;

    // Address of this edge's access: new address on load, sequenced otherwise.
    always_comb begin
        beat_nxt = step_i ? (cnt_q + 1'b1) : cnt_q;
        if (load_i)
            acc_addr_o = addr_i;
        else
            acc_addr_o = {hi_q, burst_offset(base_q, beat_nxt, linear_i)};
    end

    // Start address capture and beat counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en_i) begin
            if (load_i) begin
                {hi_q, base_q} <= addr_i;
                cnt_q          <= '0;
            end else if (step_i) begin
                cnt_q <= beat_nxt;
            end
        end
    end

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && !step_i) |=> $stable(cnt_q)) else $error("beat moved without advance"); // R5
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && load_i) |=> (cnt_q == '0)) else $error("start left beat nonzero"); // R4

endmodule

// File: rtl/psram_lane_array.sv
// Byte-lane storage with one write port and one registered read port.
// Assumes: en_i low freezes both the writes and the read register. A read
// and a write on the same edge see the array contents from before that edge.
module psram_lane_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    en_i,
    input  logic [LANES-1:0]        lane_we_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Lane write and pipelined lane read.
        always_ff @(posedge clk) begin
            if (en_i) begin
                if (lane_we_i[g])
                    cells[wr_addr_i] <= wdata_i[g*LANE_W +: LANE_W];
                rd_q <= cells[rd_addr_i];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/psram_burst_core.sv
// Pipelined burst SRAM control core, the top level. It decodes each edge,
// sequences burst addresses, and writes byte lanes at once. Reads pass
// through an address stage and an array stage. The output is qualified
// asynchronously by the output enable and by sleep.
// Assumes: linear_i is static during operation; ADDR_W > 2.
module psram_burst_core
    import psram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep_i,
    input  logic                    linear_i,
    input  logic                    ce_n_i,
    input  logic                    sel_hi_i,
    input  logic                    sel_lo_n_i,
    input  logic                    cpu_strobe_n_i,
    input  logic                    ctl_strobe_n_i,
    input  logic                    adv_n_i,
    input  logic                    all_wr_n_i,
    input  logic                    lane_wr_en_n_i,
    input  logic [LANES-1:0]        lane_sel_n_i,
    input  logic                    oe_n_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rvalid_o
);

    localparam int WORD_W = LANES * LANE_W;

    cyc_kind_t          kind;
    logic [LANES-1:0]   lane_we;
    logic               en;
    logic               wake;
    logic               load;
    logic               step;
    logic               engaged_q;
    logic               sleep_q;
    logic [ADDR_W-1:0]  acc_addr;
    logic [ADDR_W-1:0]  acc_addr_q;
    logic               acc_rd_q;
    logic               rvalid_q;
    logic [WORD_W-1:0]  rdata_q;

    // Edge qualifiers derived from sleep and the decoded kind.
    always_comb begin
        en   = ~sleep_i;
        wake = sleep_q & ~sleep_i;
        load = (kind == CYC_START_RD) || (kind == CYC_START_WR);
        step = ((kind == CYC_CONT_RD) || (kind == CYC_CONT_WR)) & ~adv_n_i;
    end

    psram_cycle_decode #(.LANES(LANES)) u_decode (
        .wake_i         (wake),
        .engaged_i      (engaged_q),
        .ce_n_i         (ce_n_i),
        .sel_hi_i       (sel_hi_i),
        .sel_lo_n_i     (sel_lo_n_i),
        .cpu_strobe_n_i (cpu_strobe_n_i),
        .ctl_strobe_n_i (ctl_strobe_n_i),
        .all_wr_n_i     (all_wr_n_i),
        .lane_wr_en_n_i (lane_wr_en_n_i),
        .lane_sel_n_i   (lane_sel_n_i),
        .kind_o         (kind),
        .lane_we_o      (lane_we)
    );

    psram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .load_i     (load),
        .step_i     (step),
        .linear_i   (linear_i),
        .addr_i     (addr_i),
        .acc_addr_o (acc_addr)
    );

    psram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .en_i      (en),
        .lane_we_i (lane_we),
        .wr_addr_i (acc_addr),
        .wdata_i   (wdata_i),
        .rd_addr_i (acc_addr_q),
        .rdata_o   (rdata_q)
    );

    // Track sleep for wake detection; not frozen by sleep itself.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sleep_q <= 1'b0;
        else
            sleep_q <= sleep_i;
    end

    // Engagement: set by a selected start, cleared by a deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)
            engaged_q <= 1'b0;
        else if (en) begin
            if (load)
                engaged_q <= 1'b1;
            else if (kind == CYC_DESEL)
                engaged_q <= 1'b0;
        end
    end

    // Read pipeline: access address stage, then the valid flag beside array data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_addr_q <= '0;
            acc_rd_q   <= 1'b0;
            rvalid_q   <= 1'b0;
        end else if (en) begin
            acc_addr_q <= acc_addr;
            acc_rd_q   <= (kind == CYC_START_RD) || (kind == CYC_CONT_RD);
            rvalid_q   <= acc_rd_q;
        end
    end

    // Asynchronous output qualification.
    assign rvalid_o = rvalid_q & ~oe_n_i & ~sleep_i;
    assign rdata_o  = rvalid_o ? rdata_q : '0;

    AST_DESEL_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && kind == CYC_DESEL) |=> !acc_rd_q) else $error("deselect left a read queued"); // R1
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!engaged_q && !load) |-> (lane_we == '0)) else $error("write while not engaged"); // R1
    AST_WRITE_STOPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lane_we != '0) |=> !acc_rd_q) else $error("write queued a read"); // R10
    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> ($stable(rvalid_q) && $stable(acc_rd_q) && $stable(engaged_q))) else $error("state moved in sleep"); // R12
    AST_WAKE_IS_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_q && !sleep_i) |-> (kind == CYC_DESEL)) else $error("wake edge not a deselect"); // R12

endmodule

// File: tb/psram_burst_core_test.sv
// Self-checking bench: sweeps burst orders, lane masks and control corners
// against a word model kept in the bench.
module psram_burst_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_i, linear_i, ce_n_i, sel_hi_i, sel_lo_n_i;
    logic        cpu_strobe_n_i, ctl_strobe_n_i, adv_n_i;
    logic        all_wr_n_i, lane_wr_en_n_i, oe_n_i;
    logic [3:0]  lane_sel_n_i;
    logic [3:0]  addr_i;
    logic [31:0] wdata_i;
    logic [31:0] rdata_o;
    logic        rvalid_o;

    logic [31:0] exp_mem [16];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    psram_burst_core #(.ADDR_W(4), .LANES(4), .LANE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .linear_i(linear_i),
        .ce_n_i(ce_n_i), .sel_hi_i(sel_hi_i), .sel_lo_n_i(sel_lo_n_i),
        .cpu_strobe_n_i(cpu_strobe_n_i), .ctl_strobe_n_i(ctl_strobe_n_i),
        .adv_n_i(adv_n_i), .all_wr_n_i(all_wr_n_i), .lane_wr_en_n_i(lane_wr_en_n_i),
        .lane_sel_n_i(lane_sel_n_i), .oe_n_i(oe_n_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    task automatic check_eq(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        sleep_i = 0; ce_n_i = 0; sel_hi_i = 1; sel_lo_n_i = 0;
        cpu_strobe_n_i = 1; ctl_strobe_n_i = 1; adv_n_i = 1;
        all_wr_n_i = 1; lane_wr_en_n_i = 1; lane_sel_n_i = 4'hF; oe_n_i = 0;
        wdata_i = 32'h0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_all(input logic [3:0] a, input logic [31:0] d);
        idle(); ctl_strobe_n_i = 0; all_wr_n_i = 0; addr_i = a; wdata_i = d;
        step();
        exp_mem[a] = d;
    endtask

    task automatic read_check(input logic [3:0] a, input string req);
        idle(); ctl_strobe_n_i = 0; addr_i = a;
        step();
        idle();
        step();
        check_eq({req, " valid"}, {31'b0, rvalid_o}, 32'd1);
        check_eq(req, rdata_o, exp_mem[a]);
    endtask

    function automatic logic [3:0] beat_addr(input logic [3:0] a, input int k, input bit lin);
        logic [1:0] kk = k[1:0];
        return {a[3:2], lin ? (a[1:0] + kk) : (a[1:0] ^ kk)};
    endfunction

    initial begin
        idle(); linear_i = 1; addr_i = 0;
        repeat (3) step();
        check_eq("R13 reset valid", {31'b0, rvalid_o}, 32'd0);
        rst_n = 1;
        step();
        check_eq("R13 post-reset valid", {31'b0, rvalid_o}, 32'd0);
        check_eq("R13 post-reset data", rdata_o, 32'd0);

        // R9: controller-strobe writes land at the new address on the same edge.
        for (int a = 0; a < 16; a++)
            write_all(a[3:0], 32'h1F2E3D4C ^ (a * 32'h01030507));
        for (int a = 0; a < 16; a++)
            read_check(a[3:0], "R9 fill readback");

        // R3/R4: every start address in both orders, four beats and the wrap.
        for (int lin = 0; lin < 2; lin++) begin
            idle(); linear_i = lin[0]; step();
            for (int a = 0; a < 16; a++) begin
                idle(); cpu_strobe_n_i = 0; addr_i = a[3:0];
                step();
                for (int k = 0; k < 5; k++) begin
                    idle(); adv_n_i = 0;
                    step();
                    check_eq("R3 beat valid", {31'b0, rvalid_o}, 32'd1);
                    check_eq("R4 beat data", rdata_o, exp_mem[beat_addr(a[3:0], k, lin[0])]);
                end
            end
        end
        idle(); linear_i = 1; step();

        // R5: advance high holds the address.
        idle(); ctl_strobe_n_i = 0; addr_i = 4'd5; step();
        idle(); step();
        check_eq("R5 hold beat0", rdata_o, exp_mem[5]);
        idle(); step();
        check_eq("R5 hold beat1", rdata_o, exp_mem[5]);
        idle(); adv_n_i = 0; step();
        check_eq("R5 hold beat2", rdata_o, exp_mem[5]);
        idle(); step();
        check_eq("R5 after advance", rdata_o, exp_mem[6]);

        // R6/R10: global write on a continuation edge overrides lane controls.
        idle(); ctl_strobe_n_i = 0; addr_i = 4'd8; step();
        idle(); all_wr_n_i = 0; lane_wr_en_n_i = 0; lane_sel_n_i = 4'b1110; wdata_i = 32'hA1B2C3D4;
        step();
        exp_mem[8] = 32'hA1B2C3D4;
        check_eq("R10 read before write valid", {31'b0, rvalid_o}, 32'd1);
        idle(); step();
        check_eq("R10 valid drops after write", {31'b0, rvalid_o}, 32'd0);
        read_check(4'd8, "R6 global override");

        // R7: all sixteen lane-select patterns.
        for (int m = 0; m < 16; m++) begin
            logic [31:0] old_w, new_w, merged;
            old_w = exp_mem[m];
            new_w = ~old_w ^ (m * 32'h00010001);
            for (int k = 0; k < 4; k++)
                merged[8*k +: 8] = m[k] ? old_w[8*k +: 8] : new_w[8*k +: 8];
            idle(); ctl_strobe_n_i = 0; lane_wr_en_n_i = 0; lane_sel_n_i = m[3:0];
            addr_i = m[3:0]; wdata_i = new_w;
            step();
            exp_mem[m] = merged;
            read_check(m[3:0], "R7 lane merge");
        end
        idle(); ctl_strobe_n_i = 0; lane_sel_n_i = 4'h0; addr_i = 4'd0; wdata_i = 32'h0BADF00D;
        step();
        idle(); step();
        check_eq("R7 enable high reads", rdata_o, exp_mem[0]);

        // R8: processor strobe, alone or with the controller strobe, ignores writes.
        idle(); cpu_strobe_n_i = 0; all_wr_n_i = 0; addr_i = 4'd3; wdata_i = 32'hDEADBEEF;
        step();
        idle(); step();
        check_eq("R8 cpu start reads", rdata_o, exp_mem[3]);
        idle(); cpu_strobe_n_i = 0; ctl_strobe_n_i = 0; lane_wr_en_n_i = 0; lane_sel_n_i = 0;
        addr_i = 4'd3; wdata_i = 32'hDEADBEEF;
        step();
        idle(); step();
        check_eq("R8 both strobes valid", {31'b0, rvalid_o}, 32'd1);
        read_check(4'd3, "R8 no write");

        // R1: unselected starts are deselects and block continuation.
        idle(); ctl_strobe_n_i = 0; sel_hi_i = 0; all_wr_n_i = 0; addr_i = 4'd2; wdata_i = 32'h12345678;
        step();
        idle(); adv_n_i = 0; all_wr_n_i = 0; wdata_i = 32'h87654321; step();
        check_eq("R1 deselect silent", {31'b0, rvalid_o}, 32'd0);
        idle(); adv_n_i = 0; step();
        check_eq("R1 no continuation", {31'b0, rvalid_o}, 32'd0);
        read_check(4'd2, "R1 no write on deselect");
        idle(); ctl_strobe_n_i = 0; ce_n_i = 1; addr_i = 4'd9; step();
        idle(); step();
        check_eq("R1 ungated strobe deselects", {31'b0, rvalid_o}, 32'd0);

        // R2: processor strobe with chip enable high continues the burst.
        idle(); cpu_strobe_n_i = 0; addr_i = 4'd4; step();
        idle(); cpu_strobe_n_i = 0; ce_n_i = 1; adv_n_i = 0; step();
        check_eq("R2 beat0", rdata_o, exp_mem[4]);
        idle(); cpu_strobe_n_i = 0; ce_n_i = 1; adv_n_i = 0; step();
        check_eq("R2 continues", rdata_o, exp_mem[5]);

        // R11: output enable acts without a clock edge.
        idle(); ctl_strobe_n_i = 0; addr_i = 4'd1; step();
        idle(); step();
        oe_n_i = 1; #1;
        check_eq("R11 oe valid off", {31'b0, rvalid_o}, 32'd0);
        check_eq("R11 oe data off", rdata_o, 32'd0);
        oe_n_i = 0; #1;
        check_eq("R11 oe restored", rdata_o, exp_mem[1]);

        // R12: sleep freezes, silences, and the wake edge deselects.
        idle(); ctl_strobe_n_i = 0; addr_i = 4'd6; step();
        idle(); sleep_i = 1; ctl_strobe_n_i = 0; all_wr_n_i = 0; wdata_i = 32'hFEEDFACE; addr_i = 4'd6;
        #1;
        check_eq("R12 sleep output off", {31'b0, rvalid_o}, 32'd0);
        step(); step();
        check_eq("R12 sleep still off", rdata_o, 32'd0);
        idle(); cpu_strobe_n_i = 0; addr_i = 4'd7; step();
        check_eq("R12 frozen read emerges", rdata_o, exp_mem[6]);
        idle(); adv_n_i = 0; step();
        check_eq("R12 wake deselect", {31'b0, rvalid_o}, 32'd0);
        idle(); adv_n_i = 0; step();
        check_eq("R12 stays disengaged", {31'b0, rvalid_o}, 32'd0);
        read_check(4'd6, "R12 no write in sleep");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule